// File: doc/BRIEF.md
# Direct-Mapped Address Translation Buffer with Access Permissions

This block translates 32-bit virtual addresses into 32-bit physical addresses for 4 kB pages through an eight-slot, direct-mapped cache of page mappings. Every memory access, read or write, goes through it. The requester presents a virtual address and an access kind. In the same cycle the block reports one of three outcomes:

- a miss;
- a permitted hit, which comes with the physical address;
- a permission-denied hit.

Each slot holds a full 20-bit page tag, a 20-bit frame number, a read-allowed bit and a write-allowed bit. Each slot also has a two-state life cycle: `SLOT_EMPTY` and `SLOT_LOADED`. The transitions are:

- *load*: EMPTY to LOADED, when a fill selects the slot;
- *reload*: LOADED to LOADED, when a fill overwrites the slot;
- *drop*: any state to EMPTY, on flush or reset.

Each lookup falls into one of three classes: `LK_MISS`, `LK_GRANT` or `LK_DENY`. The output process decodes that class.

A miss handler outside this block walks the page table. It then installs the mapping through the synchronous fill port. The slot written is chosen by the low three bits of the page number. A flush input empties every slot at once.

Top module: `xlat_tlb`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it rises, every slot is empty, so every lookup reports `xl_hit`=0.
- R2: The slot index is virtual-address bits [14:12], the low three bits of the page number. Two pages with equal bits [14:12] compete for one slot, and filling one evicts the other.
- R3: A hit needs a loaded slot whose stored 20-bit page number equals `req_vaddr[31:12]` exactly. A page that differs from the stored page in any of bits [31:15] misses.
- R4: On a permitted hit, `xl_paddr` equals the stored frame number concatenated with `req_vaddr[11:0]`. The result appears combinationally in the same cycle as the request.
- R5: On a miss, `xl_hit`=0, `xl_fault`=0 and `xl_paddr`=0. On a denied hit, `xl_paddr`=0.
- R6: A fill (`fill_en`=1) writes page, frame and permission bits into slot `fill_vpn[2:0]` at the clock edge. The mapping is visible to lookups from the next cycle on. A fill into a loaded slot replaces its contents.
- R7: `req_write`=1 marks a write and 0 marks a read. On a hit, `xl_fault`=1 exactly when a read meets `fill_rd`=0, or a write meets `fill_wr`=0, as stored. `xl_fault` is never 1 without `xl_hit`.
- R8: `flush`=1 empties all slots at the clock edge. If `flush` and `fill_en` are high together, the flush wins and the targeted slot ends up empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access kind: 1 write, 0 read |
| xl_paddr | output | 32 | Translated physical address, zero unless a permitted hit |
| xl_hit | output | 1 | Loaded slot with matching page tag |
| xl_fault | output | 1 | Hit lacking the permission for the access kind |
| fill_en | input | 1 | Install a mapping this cycle |
| fill_vpn | input | 20 | Virtual page number of the mapping (also selects the slot) |
| fill_pfn | input | 20 | Physical frame number of the mapping |
| fill_rd | input | 1 | Read permitted |
| fill_wr | input | 1 | Write permitted |
| flush | input | 1 | Empty every slot |

## Verification
The assertions check these properties on every cycle:

- a fault never appears without a hit;
- a miss or a denied hit drives a zero address;
- a permitted hit passes the page offset through unchanged;
- nothing hits in the cycle after a flush or during reset;
- a fill is visible one cycle later.

Only the bench scenarios can show the rest, because it depends on stored history:

- the correct frame number comes back for each slot;
- a tag differing in any single high bit misses;
- eviction between aliasing pages works;
- each of the four permission combinations works against both access kinds;
- flush beats a simultaneous fill.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    // Slot life cycle: a slot is either empty or holds a mapping.
    typedef enum logic {
        SLOT_EMPTY  = 1'b0,
        SLOT_LOADED = 1'b1
    } slot_state_t;

    // Outcome class of one lookup.
    typedef enum logic [1:0] {
        LK_MISS  = 2'd0,
        LK_GRANT = 2'd1,
        LK_DENY  = 2'd2
    } lk_class_t;

endpackage

// File: rtl/tlb_slot_bank.sv
module tlb_slot_bank
    import tlbx_pkg::*;
#(
    parameter int unsigned VPN_W     = 20,
    parameter int unsigned PFN_W     = 20,
    parameter int unsigned ENTRY_CNT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_rd,
    input  logic             fill_wr,
    input  logic             flush,
    output logic [VPN_W-1:0] slot_vpn [ENTRY_CNT],
    output logic [PFN_W-1:0] slot_pfn [ENTRY_CNT],
    output logic             slot_rd  [ENTRY_CNT],
    output logic             slot_wr  [ENTRY_CNT],
    output logic             slot_live[ENTRY_CNT]
);

    localparam int unsigned IDX_W = (ENTRY_CNT > 1) ? $clog2(ENTRY_CNT) : 1;

    logic [IDX_W-1:0] fill_idx;
    assign fill_idx = fill_vpn[IDX_W-1:0];

    for (genvar g = 0; g < ENTRY_CNT; g++) begin : g_slot
        slot_state_t st_q, st_d;
        logic        pick;

        assign pick = fill_en && (fill_idx == IDX_W'(g));

        // State register
        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= SLOT_EMPTY;
            else        st_q <= st_d;
        end

        // Next-state: load / reload / drop
        always_comb begin
            st_d = st_q;
            unique case (st_q)
                SLOT_EMPTY:  if (pick) st_d = SLOT_LOADED;
                SLOT_LOADED: st_d = SLOT_LOADED;
                default:     st_d = SLOT_EMPTY;
            endcase
            if (flush) st_d = SLOT_EMPTY;
        end

        // Payload written on every fill aimed at this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vpn[g] <= '0;
                slot_pfn[g] <= '0;
                slot_rd[g]  <= 1'b0;
                slot_wr[g]  <= 1'b0;
            end else if (pick) begin
                slot_vpn[g] <= fill_vpn;
                slot_pfn[g] <= fill_pfn;
                slot_rd[g]  <= fill_rd;
                slot_wr[g]  <= fill_wr;
            end
        end

        assign slot_live[g] = (st_q == SLOT_LOADED);
    end

endmodule

// File: rtl/tlb_probe.sv
module tlb_probe
    import tlbx_pkg::*;
#(
    parameter int unsigned VPN_W     = 20,
    parameter int unsigned PFN_W     = 20,
    parameter int unsigned ENTRY_CNT = 8
) (
    input  logic             req_write,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [VPN_W-1:0] slot_vpn [ENTRY_CNT],
    input  logic [PFN_W-1:0] slot_pfn [ENTRY_CNT],
    input  logic             slot_rd  [ENTRY_CNT],
    input  logic             slot_wr  [ENTRY_CNT],
    input  logic             slot_live[ENTRY_CNT],
    output lk_class_t        lk_class,
    output logic [PFN_W-1:0] lk_pfn
);

    localparam int unsigned IDX_W = (ENTRY_CNT > 1) ? $clog2(ENTRY_CNT) : 1;

    logic [IDX_W-1:0] idx;
    logic             tag_eq;
    logic             perm_ok;

    assign idx     = req_vpn[IDX_W-1:0];
    assign tag_eq  = slot_live[idx] && (slot_vpn[idx] == req_vpn);
    assign perm_ok = req_write ? slot_wr[idx] : slot_rd[idx];
    assign lk_pfn  = slot_pfn[idx];

    always_comb begin
        if (!tag_eq)      lk_class = LK_MISS;
        else if (perm_ok) lk_class = LK_GRANT;
        else              lk_class = LK_DENY;
    end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import tlbx_pkg::*;
#(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PA_W      = 32,
    parameter int unsigned OFS_W     = 12,
    parameter int unsigned ENTRY_CNT = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  req_write,
    output logic [PA_W-1:0]       xl_paddr,
    output logic                  xl_hit,
    output logic                  xl_fault,
    input  logic                  fill_en,
    input  logic [VA_W-OFS_W-1:0] fill_vpn,
    input  logic [PA_W-OFS_W-1:0] fill_pfn,
    input  logic                  fill_rd,
    input  logic                  fill_wr,
    input  logic                  flush
);

    localparam int unsigned VPN_W = VA_W - OFS_W;
    localparam int unsigned PFN_W = PA_W - OFS_W;

    logic [VPN_W-1:0] slot_vpn [ENTRY_CNT];
    logic [PFN_W-1:0] slot_pfn [ENTRY_CNT];
    logic             slot_rd  [ENTRY_CNT];
    logic             slot_wr  [ENTRY_CNT];
    logic             slot_live[ENTRY_CNT];
    lk_class_t        lk_class;
    logic [PFN_W-1:0] lk_pfn;

    tlb_slot_bank #(
        .VPN_W(VPN_W), .PFN_W(PFN_W), .ENTRY_CNT(ENTRY_CNT)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_rd(fill_rd), .fill_wr(fill_wr), .flush(flush),
        .slot_vpn(slot_vpn), .slot_pfn(slot_pfn),
        .slot_rd(slot_rd), .slot_wr(slot_wr), .slot_live(slot_live)
    );

    tlb_probe #(
        .VPN_W(VPN_W), .PFN_W(PFN_W), .ENTRY_CNT(ENTRY_CNT)
    ) u_probe (
        .req_write(req_write), .req_vpn(req_vaddr[VA_W-1:OFS_W]),
        .slot_vpn(slot_vpn), .slot_pfn(slot_pfn),
        .slot_rd(slot_rd), .slot_wr(slot_wr), .slot_live(slot_live),
        .lk_class(lk_class), .lk_pfn(lk_pfn)
    );

    // Output process: decode the lookup class
    always_comb begin
        xl_hit   = 1'b0;
        xl_fault = 1'b0;
        xl_paddr = '0;
        unique case (lk_class)
            LK_MISS: ;
            LK_GRANT: begin
                xl_hit   = 1'b1;
                xl_paddr = {lk_pfn, req_vaddr[OFS_W-1:0]};
            end
            LK_DENY: begin
                xl_hit   = 1'b1;
                xl_fault = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned OFS_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [VA_W-1:0]       req_vaddr,
    input logic [PA_W-1:0]       xl_paddr,
    input logic                  xl_hit,
    input logic                  xl_fault,
    input logic                  fill_en,
    input logic [VA_W-OFS_W-1:0] fill_vpn,
    input logic                  flush
);

    // R7
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> xl_hit);

    // R5
    zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xl_hit || xl_fault) |-> (xl_paddr == '0));

    // R4
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_hit && !xl_fault) |-> (xl_paddr[OFS_W-1:0] == req_vaddr[OFS_W-1:0]));

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !xl_hit);

    // R6
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=>
            ((req_vaddr[VA_W-1:OFS_W] != $past(fill_vpn)) || xl_hit));

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> !xl_hit);

endmodule

bind xlat_tlb xlat_tlb_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_vaddr(req_vaddr),
    .xl_paddr(xl_paddr), .xl_hit(xl_hit), .xl_fault(xl_fault),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .flush(flush)
);

// File: tb/xlat_tlb_test.sv
`timescale 1ns/1ps
module xlat_tlb_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] xl_paddr;
    logic        xl_hit, xl_fault;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_rd = 1'b0, fill_wr = 1'b0;
    logic        flush = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model of slot contents
    logic [19:0] m_vpn [8];
    logic [19:0] m_pfn [8];
    logic        m_rd [8], m_wr [8], m_v [8];

    always #2 clk = ~clk;

    xlat_tlb uut (
        .clk(clk), .rst_n(rst_n), .req_vaddr(req_vaddr), .req_write(req_write),
        .xl_paddr(xl_paddr), .xl_hit(xl_hit), .xl_fault(xl_fault),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_rd(fill_rd), .fill_wr(fill_wr), .flush(flush)
    );

    task automatic look(input logic [31:0] va, input logic wr, input string tag);
        logic [2:0]  ix;
        logic        eh, ef;
        logic [31:0] ep;
        @(negedge clk);
        req_vaddr = va;
        req_write = wr;
        #1;
        ix = va[14:12];
        eh = m_v[ix] && (m_vpn[ix] == va[31:12]);
        ef = eh && (wr ? !m_wr[ix] : !m_rd[ix]);
        ep = (eh && !ef) ? {m_pfn[ix], va[11:0]} : 32'h0;
        checks++;
        if (xl_hit !== eh || xl_fault !== ef || xl_paddr !== ep) begin
            errors++;
            $display("FAIL %s va=%h wr=%0d: got hit=%0d fault=%0d pa=%h, expected hit=%0d fault=%0d pa=%h",
                     tag, va, wr, xl_hit, xl_fault, xl_paddr, eh, ef, ep);
        end
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn,
                           input logic rd, input logic wr, input logic fl);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
        fill_rd = rd; fill_wr = wr; flush = fl;
        @(negedge clk);
        fill_en = 1'b0; flush = 1'b0;
        if (fl) begin
            for (int k = 0; k < 8; k++) m_v[k] = 1'b0;
        end else begin
            m_vpn[vpn[2:0]] = vpn; m_pfn[vpn[2:0]] = pfn;
            m_rd[vpn[2:0]] = rd;   m_wr[vpn[2:0]] = wr;
            m_v[vpn[2:0]] = 1'b1;
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int k = 0; k < 8; k++) m_v[k] = 1'b0;
    endtask

    function automatic logic [19:0] vpn_of(input int i);
        return {17'(i * 37 + 5), 3'(i)};
    endfunction

    function automatic logic [19:0] pfn_of(input int i);
        return 20'(i * 40503) ^ 20'h5A5A5;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) begin
            m_v[k] = 0; m_vpn[k] = 0; m_pfn[k] = 0; m_rd[k] = 0; m_wr[k] = 0;
        end
        // R1: reset state, probe every slot during and after reset
        repeat (3) @(posedge clk);
        for (int i = 0; i < 8; i++) look({vpn_of(i), 12'h000}, 1'b0, "R1");
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 8; i++) look({vpn_of(i), 12'h123}, 1'b1, "R1");

        // R6/R7: fill all slots, permissions rd=i[0], wr=i[1]
        for (int i = 0; i < 8; i++) do_fill(vpn_of(i), pfn_of(i), 1'(i), 1'(i >> 1), 1'b0);
        // R4/R7: sweep slots x access kind x offsets
        for (int i = 0; i < 8; i++)
            for (int w = 0; w < 2; w++) begin
                look({vpn_of(i), 12'h000}, 1'(w), "R4_R7");
                look({vpn_of(i), 12'hFFF}, 1'(w), "R4_R7");
                look({vpn_of(i), 12'(i * 291)}, 1'(w), "R4_R7");
            end

        // R3: single-bit tag difference above the index misses
        for (int b = 15; b < 32; b++) look({vpn_of(3), 12'h0AA} ^ (32'h1 << b), 1'b0, "R3");

        // R2: alias into slot 2 evicts old page
        do_fill(vpn_of(2) ^ 20'h80, 20'hBEEF1, 1'b1, 1'b1, 1'b0);
        look({vpn_of(2), 12'h010}, 1'b0, "R2");
        look({vpn_of(2) ^ 20'h80, 12'h010}, 1'b1, "R2");
        look({vpn_of(5), 12'h010}, 1'b0, "R2");

        // R7/R6: every permission combination on slot 6, reload in place
        for (int p = 0; p < 4; p++) begin
            do_fill(vpn_of(6), 20'(p + 20'h30000), 1'(p), 1'(p >> 1), 1'b0);
            look({vpn_of(6), 12'h444}, 1'b0, "R7");
            look({vpn_of(6), 12'h444}, 1'b1, "R7");
        end

        // R5: miss after flush gives zero address
        do_flush();
        for (int i = 0; i < 8; i++) look({vpn_of(i), 12'hFFF}, 1'(i), "R8");
        look({vpn_of(4), 12'h777}, 1'b0, "R5");

        // R8: flush wins over simultaneous fill
        do_fill(vpn_of(1), 20'h12345, 1'b1, 1'b1, 1'b1);
        look({vpn_of(1), 12'h001}, 1'b0, "R8");
        do_fill(vpn_of(1), 20'h12345, 1'b1, 1'b1, 1'b0);
        look({vpn_of(1), 12'h001}, 1'b0, "R6");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule